// File: doc/BRIEF.md
# Serial Flash Clock and Select Timing Generator

This block produces the serial clock and the device-select lines for a quad serial flash master. An upstream sequencer asks for a transfer and later asks for it to end. Between those two requests the block runs the serial clock at the reference clock divided by 2×(divisor+1). Three things can be set: the clock polarity and phase, one of two ways of driving the select lines, and four guard counts in reference-clock cycles. The guards place the select edges around the clock burst, hold the select lines high between transfers, and add a pause when the addressed device changes. It also pulses a shift strobe and a sample strobe toward a datapath on opposite clock edges, and it reports when no transfer is active.

All configuration is taken when a request is accepted in the idle state, so a change made during a transfer applies to the next one. A guard count G stands for G+1 reference cycles. The enable input gates everything: while it is low, requests are ignored, and dropping it during a transfer aborts the transfer.

Top module: `spi_flash_clkcs_gen`

## Requirements
- R1: After reset, idle is 1, all four select lines are 1, sclk equals cfg_cpol and both strobes are 0.
- R2: During a transfer, successive sclk edges are exactly cfg_baud_div+1 reference cycles apart, so the period is 2×(cfg_baud_div+1) cycles.
- R3: While idle, sclk follows cfg_cpol with one cycle of latency. The first edge of a transfer drives sclk to the opposite level, and the last edge returns it to cfg_cpol.
- R4: With cfg_cs_decode=1, cs_n during a transfer equals cfg_cs_field bit for bit (bit i to line i).
- R5: With cfg_cs_decode=0, cs_n during a transfer has line n low and the other lines high, where n is cfg_cs_field[1:0]. Bits [3:2] are ignored.
- R6: The first sclk edge comes cfg_dly_setup+cfg_baud_div+2 cycles after cs_n asserts.
- R7: The transfer ends on the first trailing edge, the one that returns sclk to the idle level, that comes after done_req is seen (done_req is remembered from the setup phase on). cs_n releases cfg_dly_hold+1 cycles after that edge.
- R8: When the next transfer targets the same select pattern and xfer_req is waiting, cs_n reasserts exactly cfg_dly_gap+2 cycles after it released. A request accepted in idle for the same pattern asserts cs_n on the accepting edge.
- R9: When an accepted request targets a select pattern different from the previous transfer, cs_n asserts cfg_dly_switch+1 cycles after the accepting edge.
- R10: With cfg_cpha=0, sample_stb pulses on leading edges (odd-numbered edges, counting from 1) and shift_stb on trailing edges. With cfg_cpha=1 the roles swap. Each pulse lasts one cycle and appears in the same cycle as the sclk change it belongs to, and no strobe appears at any other time.
- R11: While cfg_enable=0, xfer_req is ignored. Dropping cfg_enable during a transfer makes idle=1 and releases all select lines on the next clock edge.
- R12: Changes to cfg_baud_div or cfg_cs_field after acceptance do not affect the running transfer.
- R13: idle is 0 whenever any select line is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Gates all activity |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase: selects the edges the strobes use |
| cfg_baud_div | input | 4 | Half period minus one, in reference cycles |
| cfg_cs_field | input | 4 | Raw select pattern or select index |
| cfg_cs_decode | input | 1 | 1: drive field raw; 0: one-hot active-low from index |
| cfg_dly_setup | input | 8 | Guard from select assertion to the clock burst |
| cfg_dly_hold | input | 8 | Guard from the last clock edge to select release |
| cfg_dly_gap | input | 8 | Minimum select-high guard between transfers |
| cfg_dly_switch | input | 8 | Extra guard when the target device changes |
| xfer_req | input | 1 | Start request from the sequencer |
| done_req | input | 1 | End request from the sequencer |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Select lines, low asserts |
| shift_stb | output | 1 | One-cycle strobe: drive next bit |
| sample_stb | output | 1 | One-cycle strobe: capture input bit |
| idle | output | 1 | No transfer active |

## Verification
Every output is registered. A request seen at a clock edge changes cs_n at that same edge, or cfg_dly_switch+1 edges later when the device changes. The first sclk change follows cfg_dly_setup+cfg_baud_div+2 edges after that. cs_n releases cfg_dly_hold+1 edges after the closing sclk edge, and strobes coincide with the sclk change. The bench drives inputs on falling edges and stamps every observed change with a falling-edge cycle counter, so each expected value is a plain difference of two stamps computed from the requirement formulas.

// File: rtl/spi_clkcs_pkg.sv
// Shared types for the serial flash clock and select generator.
package spi_clkcs_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Sequencer phases, in the order a transfer walks through them.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SWITCH = 3'd1,
        ST_SETUP  = 3'd2,
        ST_RUN    = 3'd3,
        ST_HOLD   = 3'd4,
        ST_GAP    = 3'd5
    } seq_state_e;
endpackage

// File: rtl/spi_clkcs_cs_encode.sv
// Select encoder: turns the configured field into an active-low line
// pattern. Raw mode passes the field through for an external decoder;
// otherwise the low index bits pick the single line driven low.
// Assumes NUM_CS is a power of two and at least 2.
module spi_clkcs_cs_encode #(
    parameter int NUM_CS = 4
) (
    input  logic [NUM_CS-1:0] field_i,
    input  logic              decode_i,
    output logic [NUM_CS-1:0] pattern_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int IDX_W = $clog2(NUM_CS);

    logic [IDX_W-1:0] index;
    assign index = field_i[IDX_W-1:0];

    // One mux per select line: raw bit or index compare.
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        assign pattern_o[i] = decode_i ? field_i[i] : (index != IDX_W'(i));
    end

    // Index mode must leave exactly one line low (R5).
    always_comb begin
        if (!decode_i && !$isunknown(field_i)) begin
            assert_onehot_low_R5: assert ($countones(~pattern_o) == 1)
                else $error("index mode produced %b", pattern_o);
        end
    end
endmodule

// File: rtl/spi_clkcs_half_timer.sv
// Half-period timer: while run_i is high it counts reference cycles and
// raises tick_o on every (div_i+1)-th cycle, marking an sclk edge.
// Assumes div_i is stable while run_i is high.
module spi_clkcs_half_timer #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [DIV_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == div_i);

    // Count up within a half period, restart on tick or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // The count never passes the divisor while running (R2).
    assert_half_cnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q <= div_i))
        else $error("half counter beyond divisor");
endmodule

// File: rtl/spi_clkcs_seq.sv
// Transfer sequencer: takes a request in idle, latches configuration, then
// walks switch guard, setup guard, clock burst, hold guard and gap guard.
// It owns the sclk, select and strobe registers. A guard count G lasts
// G+1 cycles. Assumes tick_i comes from a timer fed by div_o and run_o.
module spi_clkcs_seq
    import spi_clkcs_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int DIV_W  = 4,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [NUM_CS-1:0] pat_i,
    input  logic [DLY_W-1:0]  cfg_dly_setup,
    input  logic [DLY_W-1:0]  cfg_dly_hold,
    input  logic [DLY_W-1:0]  cfg_dly_gap,
    input  logic [DLY_W-1:0]  cfg_dly_switch,
    input  logic              xfer_req,
    input  logic              done_req,
    input  logic              tick_i,
    output logic              run_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              sclk_o,
    output logic [NUM_CS-1:0] cs_n_o,
    output logic              shift_o,
    output logic              sample_o,
    output logic              idle_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [NUM_CS-1:0] CS_OFF = '1;

    seq_state_e        state_q;
    logic [DLY_W-1:0]  cnt_q;
    logic              sclk_q, shift_q, sample_q, trail_q, pend_q;
    logic [NUM_CS-1:0] cs_q, l_pat, last_pat_q;
    logic              last_ok_q, l_cpha;
    logic [DIV_W-1:0]  l_div;
    logic [DLY_W-1:0]  l_setup, l_hold, l_gap;
    logic              accept, switch_dev;

    assign accept     = cfg_enable && xfer_req && (state_q == ST_IDLE);
    assign switch_dev = last_ok_q && (pat_i != last_pat_q);

    // Latch the configuration on acceptance; it stays frozen for the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_cpha     <= 1'b0;
            l_div      <= '0;
            l_pat      <= CS_OFF;
            l_setup    <= '0;
            l_hold     <= '0;
            l_gap      <= '0;
            last_pat_q <= CS_OFF;
            last_ok_q  <= 1'b0;
        end else if (accept) begin
            l_cpha     <= cfg_cpha;
            l_div      <= cfg_div;
            l_pat      <= pat_i;
            l_setup    <= cfg_dly_setup;
            l_hold     <= cfg_dly_hold;
            l_gap      <= cfg_dly_gap;
            last_pat_q <= pat_i;
            last_ok_q  <= 1'b1;
        end
    end

    // Phase walk with guard counter, sclk, select and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            sclk_q   <= cfg_cpol;
            cs_q     <= CS_OFF;
            shift_q  <= 1'b0;
            sample_q <= 1'b0;
            trail_q  <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            shift_q  <= 1'b0;
            sample_q <= 1'b0;
            if (!cfg_enable && state_q != ST_IDLE) begin
                state_q <= ST_IDLE;
                cs_q    <= CS_OFF;
                sclk_q  <= cfg_cpol;
                pend_q  <= 1'b0;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        sclk_q <= cfg_cpol;
                        pend_q <= 1'b0;
                        if (accept) begin
                            if (switch_dev) begin
                                state_q <= ST_SWITCH;
                                cnt_q   <= cfg_dly_switch;
                            end else begin
                                state_q <= ST_SETUP;
                                cnt_q   <= cfg_dly_setup;
                                cs_q    <= pat_i;
                            end
                        end
                    end
                    ST_SWITCH: begin
                        if (cnt_q == '0) begin
                            state_q <= ST_SETUP;
                            cnt_q   <= l_setup;
                            cs_q    <= l_pat;
                        end else begin
                            cnt_q <= cnt_q - DLY_W'(1);
                        end
                    end
                    ST_SETUP: begin
                        pend_q <= pend_q | done_req;
                        if (cnt_q == '0) begin
                            state_q <= ST_RUN;
                            trail_q <= 1'b0;
                        end else begin
                            cnt_q <= cnt_q - DLY_W'(1);
                        end
                    end
                    ST_RUN: begin
                        pend_q <= pend_q | done_req;
                        if (tick_i) begin
                            sclk_q   <= ~sclk_q;
                            trail_q  <= ~trail_q;
                            shift_q  <= trail_q ? ~l_cpha : l_cpha;
                            sample_q <= trail_q ? l_cpha : ~l_cpha;
                            if (trail_q && (pend_q || done_req)) begin
                                state_q <= ST_HOLD;
                                cnt_q   <= l_hold;
                                pend_q  <= 1'b0;
                            end
                        end
                    end
                    ST_HOLD: begin
                        if (cnt_q == '0) begin
                            state_q <= ST_GAP;
                            cnt_q   <= l_gap;
                            cs_q    <= CS_OFF;
                        end else begin
                            cnt_q <= cnt_q - DLY_W'(1);
                        end
                    end
                    ST_GAP: begin
                        if (cnt_q == '0) begin
                            state_q <= ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q - DLY_W'(1);
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign run_o    = (state_q == ST_RUN);
    assign div_o    = l_div;
    assign sclk_o   = sclk_q;
    assign cs_n_o   = cs_q;
    assign shift_o  = shift_q;
    assign sample_o = sample_q;
    assign idle_o   = (state_q == ST_IDLE);

    // Idle never coexists with an asserted select line (R13).
    assert_idle_cs_high_R13: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> (cs_n_o == CS_OFF))
        else $error("select asserted while idle");

    // A resting clock follows the polarity bit (R3).
    assert_idle_sclk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && $past(idle_o)) |-> (sclk_o == $past(cfg_cpol)))
        else $error("idle clock level wrong");

    // Strobes are exclusive (R10).
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shift_o, sample_o}))
        else $error("both strobes high");

    // A strobe only accompanies an sclk change (R10).
    assert_strobe_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_o || sample_o) |-> (sclk_o != $past(sclk_o)))
        else $error("strobe without clock edge");

    // Enable low forces idle on the next edge (R11).
    assert_enable_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> idle_o)
        else $error("activity while disabled");
endmodule

// File: rtl/spi_flash_clkcs_gen.sv
// Top: serial flash clock and select timing generator. Encodes the select
// pattern from live configuration, and connects the half-period timer and
// the transfer sequencer. All outputs come straight from registers.
module spi_flash_clkcs_gen #(
    parameter int NUM_CS = 4,
    parameter int DIV_W  = 4,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [DIV_W-1:0]  cfg_baud_div,
    input  logic [NUM_CS-1:0] cfg_cs_field,
    input  logic              cfg_cs_decode,
    input  logic [DLY_W-1:0]  cfg_dly_setup,
    input  logic [DLY_W-1:0]  cfg_dly_hold,
    input  logic [DLY_W-1:0]  cfg_dly_gap,
    input  logic [DLY_W-1:0]  cfg_dly_switch,
    input  logic              xfer_req,
    input  logic              done_req,
    output logic              sclk,
    output logic [NUM_CS-1:0] cs_n,
    output logic              shift_stb,
    output logic              sample_stb,
    output logic              idle
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [NUM_CS-1:0] pat;
    logic              run, tick;
    logic [DIV_W-1:0]  div_l;

    spi_clkcs_cs_encode #(.NUM_CS(NUM_CS)) u_enc (
        .field_i   (cfg_cs_field),
        .decode_i  (cfg_cs_decode),
        .pattern_o (pat)
    );

    spi_clkcs_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div_i  (div_l),
        .tick_o (tick)
    );

    spi_clkcs_seq #(.NUM_CS(NUM_CS), .DIV_W(DIV_W), .DLY_W(DLY_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_enable     (cfg_enable),
        .cfg_cpol       (cfg_cpol),
        .cfg_cpha       (cfg_cpha),
        .cfg_div        (cfg_baud_div),
        .pat_i          (pat),
        .cfg_dly_setup  (cfg_dly_setup),
        .cfg_dly_hold   (cfg_dly_hold),
        .cfg_dly_gap    (cfg_dly_gap),
        .cfg_dly_switch (cfg_dly_switch),
        .xfer_req       (xfer_req),
        .done_req       (done_req),
        .tick_i         (tick),
        .run_o          (run),
        .div_o          (div_l),
        .sclk_o         (sclk),
        .cs_n_o         (cs_n),
        .shift_o        (shift_stb),
        .sample_o       (sample_stb),
        .idle_o         (idle)
    );
endmodule

// File: tb/spi_flash_clkcs_gen_tb.sv
// Bench for the clock and select generator: a vector table walked by one
// loop, then directed tests for reset, guards, enable and config freezing.
module spi_flash_clkcs_gen_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_cs_decode = 1'b0;
    logic [3:0] cfg_baud_div = '0, cfg_cs_field = '0;
    logic [7:0] cfg_dly_setup = '0, cfg_dly_hold = '0, cfg_dly_gap = '0, cfg_dly_switch = '0;
    logic xfer_req = 1'b0, done_req = 1'b0;
    logic sclk, shift_stb, sample_stb, idle;
    logic [3:0] cs_n;

    always #4 clk = ~clk;

    spi_flash_clkcs_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_baud_div(cfg_baud_div), .cfg_cs_field(cfg_cs_field),
        .cfg_cs_decode(cfg_cs_decode), .cfg_dly_setup(cfg_dly_setup),
        .cfg_dly_hold(cfg_dly_hold), .cfg_dly_gap(cfg_dly_gap),
        .cfg_dly_switch(cfg_dly_switch), .xfer_req(xfer_req), .done_req(done_req),
        .sclk(sclk), .cs_n(cs_n), .shift_stb(shift_stb), .sample_stb(sample_stb),
        .idle(idle)
    );

    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic [3:0] div;
        logic       dec;
        logic [3:0] csf;
        logic [7:0] setup;
        logic [7:0] hold;
        logic [3:0] nper;
        logic [3:0] pat;   // expected cs_n while asserted
        logic [7:0] half;  // expected div+1
        logic [7:0] lead;  // expected setup+div+2
        logic [7:0] tail;  // expected hold+1
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 4'd0,  1'b0, 4'd0,    8'd0, 8'd0, 4'd2, 4'b1110, 8'd1,  8'd2,  8'd1},
        '{1'b1, 1'b0, 4'd1,  1'b0, 4'd2,    8'd3, 8'd2, 4'd1, 4'b1011, 8'd2,  8'd6,  8'd3},
        '{1'b0, 1'b1, 4'd3,  1'b1, 4'b1010, 8'd1, 8'd0, 4'd2, 4'b1010, 8'd4,  8'd6,  8'd1},
        '{1'b1, 1'b1, 4'd15, 1'b0, 4'd3,    8'd0, 8'd5, 4'd1, 4'b0111, 8'd16, 8'd17, 8'd6},
        '{1'b0, 1'b1, 4'd2,  1'b0, 4'b1101, 8'd2, 8'd1, 4'd3, 4'b1101, 8'd3,  8'd6,  8'd2},
        '{1'b1, 1'b0, 4'd0,  1'b1, 4'b0000, 8'd0, 8'd0, 4'd1, 4'b0000, 8'd1,  8'd2,  8'd1}
    };

    int n_tests = 0, n_fail = 0;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: stamps every observed change with a falling-edge cycle count.
    int cyc = 0, nfall = 0, nedge = 0, t_fall = 0, t_rise = 0, t_first = 0, t_last = 0;
    int hmin = 1000, hmax = 0, last_gap = -1, strobe_err = 0, idle_err = 0;
    logic have_rise = 1'b0, act_p = 1'b0, sclk_p = 1'b0, first_val = 1'b0;
    logic [3:0] pat_seen = '1;

    always @(negedge clk) begin
        logic act, lead, exp_smp;
        cyc = cyc + 1;
        act = (cs_n != 4'hF);
        if (act && !act_p) begin
            t_fall = cyc; nfall++;
            if (have_rise) last_gap = cyc - t_rise;
            nedge = 0; hmin = 1000; hmax = 0; pat_seen = cs_n;
        end
        if (!act && act_p) begin
            t_rise = cyc; have_rise = 1'b1;
        end
        if (act && sclk !== sclk_p) begin
            nedge++;
            if (nedge == 1) begin
                t_first = cyc; first_val = sclk;
            end else begin
                if (cyc - t_last < hmin) hmin = cyc - t_last;
                if (cyc - t_last > hmax) hmax = cyc - t_last;
            end
            t_last = cyc;
            lead = nedge[0];
            exp_smp = lead ^ cfg_cpha;
            if (sample_stb !== exp_smp || shift_stb !== !exp_smp) strobe_err++;
        end else if (shift_stb || sample_stb) begin
            strobe_err++;
        end
        if (act && idle) idle_err++;
        sclk_p = sclk;
        act_p = act;
    end

    task automatic tick_wait;
        @(negedge clk); #1;
    endtask

    task automatic wait_idle;
        while (!idle) tick_wait();
    endtask

    // One transfer of nper clock periods; optionally alters config mid-way.
    task automatic run_xfer(input int nper, input bit change_mid);
        int nf0;
        wait_idle();
        nf0 = nfall;
        xfer_req = 1'b1;
        tick_wait();
        xfer_req = 1'b0;
        if (change_mid) begin
            cfg_baud_div = 4'd5;
            cfg_cs_field = 4'd2;
        end
        while (nfall == nf0) tick_wait();
        while (nedge < 2 * nper - 1) tick_wait();
        done_req = 1'b1;
        tick_wait();
        done_req = 1'b0;
        wait_idle();
        tick_wait();
    endtask

    // Measure cycles from request raise to select assertion.
    task automatic start_delay(input string req, input int exp, input bit do_check);
        int c, nf0;
        wait_idle();
        repeat (3) tick_wait();
        nf0 = nfall;
        c = cyc;
        xfer_req = 1'b1;
        done_req = 1'b1;
        tick_wait();
        xfer_req = 1'b0;
        while (nfall == nf0) tick_wait();
        if (do_check) check(req, t_fall - c, exp);
        wait_idle();
        done_req = 1'b0;
        tick_wait();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        cfg_dly_switch = 8'd1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        tick_wait();
        // R1: reset state
        check("R1 idle", int'(idle), 1);
        check("R1 cs_n", int'(cs_n), 15);
        check("R1 sclk", int'(sclk), 0);
        check("R1 strobes", int'({shift_stb, sample_stb}), 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R10 R13
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            cfg_cpol = v.cpol; cfg_cpha = v.cpha; cfg_baud_div = v.div;
            cfg_cs_decode = v.dec; cfg_cs_field = v.csf;
            cfg_dly_setup = v.setup; cfg_dly_hold = v.hold;
            tick_wait();
            run_xfer(int'(v.nper), 1'b0);
            check(v.dec ? "R4 pattern" : "R5 pattern", int'(pat_seen), int'(v.pat));
            check("R2 half min", hmin, int'(v.half));
            check("R2 half max", hmax, int'(v.half));
            check("R6 lead", t_first - t_fall, int'(v.lead));
            check("R7 tail", t_rise - t_last, int'(v.tail));
            check("R7 edges", nedge, 2 * int'(v.nper));
            check("R3 first edge", int'(first_val), int'(!v.cpol));
            check("R3 idle level", int'(sclk), int'(v.cpol));
            check("R10 strobes", strobe_err, 0);
            check("R13 idle", idle_err, 0);
        end

        // R3: idle clock follows polarity change
        cfg_cpol = 1'b0;
        tick_wait(); tick_wait();
        check("R3 idle follow", int'(sclk), 0);

        // R12: config changed after acceptance is ignored
        cfg_cpha = 1'b0; cfg_cs_decode = 1'b0; cfg_cs_field = 4'd0;
        cfg_baud_div = 4'd1; cfg_dly_setup = 8'd0; cfg_dly_hold = 8'd0;
        tick_wait();
        run_xfer(2, 1'b1);
        check("R12 half", hmax, 2);
        check("R12 half min", hmin, 2);
        check("R12 pattern", int'(pat_seen), 14);

        // R8 / R9: select assertion after acceptance
        cfg_baud_div = 4'd0; cfg_dly_gap = 8'd3; cfg_dly_switch = 8'd2;
        cfg_cs_field = 4'd0;
        start_delay("R8", 0, 1'b0);
        start_delay("R8 same device", 1, 1'b1);
        cfg_cs_field = 4'd1;
        start_delay("R9 switch device", 4, 1'b1);

        // R8: back-to-back gap with request waiting
        begin
            int nf0;
            wait_idle();
            nf0 = nfall;
            xfer_req = 1'b1; done_req = 1'b1;
            while (nfall < nf0 + 2) tick_wait();
            xfer_req = 1'b0;
            check("R8 gap", last_gap, 5);
            wait_idle();
            done_req = 1'b0;
            repeat (3) tick_wait();
        end

        // R11: requests ignored while disabled
        begin
            int nf0;
            nf0 = nfall;
            cfg_enable = 1'b0;
            xfer_req = 1'b1;
            repeat (4) tick_wait();
            xfer_req = 1'b0;
            check("R11 idle", int'(idle), 1);
            check("R11 cs_n", int'(cs_n), 15);
            check("R11 no start", nfall - nf0, 0);
            cfg_enable = 1'b1;
            cfg_baud_div = 4'd3;
            tick_wait();
            xfer_req = 1'b1;
            tick_wait();
            xfer_req = 1'b0;
            while (nedge < 1 || !act_p) tick_wait();
            cfg_enable = 1'b0;
            tick_wait();
            check("R11 abort idle", int'(idle), 1);
            check("R11 abort cs_n", int'(cs_n), 15);
            check("R11 abort sclk", int'(sclk), 0);
            cfg_enable = 1'b1;
            tick_wait();
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule